// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch state of one hardware thread in a multithreaded front end. Each cycle it combines four kinds of input into one next status: stall requests from four downstream pipeline stages, redirects from a late and an early pipeline stage, instruction-cache events (request sent, request refused, retry accepted, response returned), and events seen while fetching (translation fault, quiesce instruction). The result is a 4-bit status code. The thread arbiter uses this code to decide whether the thread may take a fetch turn.

A redirect that the controller acts on produces a one-cycle redirect strobe carrying the new PC. When a cache response does not belong to the outstanding request, a drop strobe marks it as discarded. Two saturating counters record how many cycles the thread has spent blocked and how many it has spent squashing.

Top module: `fetch_thread_ctl`

## Requirements
- R1: Each downstream stage owns a sticky stall flag. A pulse on its `blk_set` bit sets the flag from the next cycle on. A pulse on its `blk_clr` bit clears it. Both bits of one stage are never high in the same cycle. The thread stays stalled while any flag is set.
- R2: A late squash wins over every other input. One cycle later the status is Squashing (2), `redirect_vld` is 1 and `redirect_pc` equals the `late_pc` of the squash cycle.
- R3: While `late_busy` is high, the next status is Squashing (2), whatever else is requested.
- R4: An early squash is acted on only when the current status is not Squashing. It then redirects to `early_pc` and enters Squashing. When the status is already Squashing, it produces no redirect and the status stays Squashing.
- R5: When a stall flag is set after this cycle's updates, or `ctx_stall` is high, the next status is Blocked (3). The exceptions are Cache Wait Response (4), Cache Wait Retry (5), Trap Pending (7) and Quiesce Pending (8), which keep their state.
- R6: When the status is Blocked or Squashing and a cycle brings no stall and no squash, the next status is Running (1).
- R7: A squash abandons an outstanding cache request or a pending retry. A response that arrives later is dropped.
- R8: A cache response is accepted only when the status is Cache Wait Response, `rsp_tag` equals the tag recorded when the request went out, and no squash acts in that cycle. Any other response raises `drop_rsp` in the same cycle and has no other effect.
- R9: An accepted response moves the status to Blocked (3) if a stall is active, and otherwise to Cache Access Complete (6). Cache Access Complete and Idle (0) both move to Running on a cycle with `fetch_turn` high.
- R10: On a fetch turn in Running, `miss_send` moves the status to Cache Wait Response (4) and records `req_tag`. If `miss_nack` is also high, the status moves to Cache Wait Retry (5) instead. In that state, `retry_ok` records `req_tag` and moves the status to Cache Wait Response.
- R11: On a fetch turn in Running, `trap_evt` moves the status to Trap Pending (7). Without a trap, send or refusal, `quiesce_evt` moves it to Quiesce Pending (8). Only a squash leaves either of these states.
- R12: `stall_cycles` counts the cycles in which the status is Blocked. `squash_cycles` counts the cycles in which it is Squashing. Each counter stops at its all-ones value.
- R13: During reset the status is Idle (0), `redirect_vld` is 0 and both counters are 0. The status codes are Idle 0, Running 1, Squashing 2, Blocked 3, Cache Wait Response 4, Cache Wait Retry 5, Cache Access Complete 6, Trap Pending 7 and Quiesce Pending 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_set | input | NSTG | Per-stage stall set pulses |
| blk_clr | input | NSTG | Per-stage stall clear pulses |
| ctx_stall | input | 1 | Global context-switch stall |
| late_sq | input | 1 | Squash request from the late stage |
| late_pc | input | PC_W | Redirect PC of the late squash |
| late_busy | input | 1 | Late stage still squashing |
| early_sq | input | 1 | Squash request from the early stage |
| early_pc | input | PC_W | Redirect PC of the early squash |
| fetch_turn | input | 1 | This thread holds the fetch slot this cycle |
| miss_send | input | 1 | Cache request presented on this turn |
| miss_nack | input | 1 | Presented request refused by the cache |
| retry_ok | input | 1 | Retried request accepted |
| req_tag | input | TAG_W | Tag of the request sent or retried |
| rsp_valid | input | 1 | Cache response arrives |
| rsp_tag | input | TAG_W | Tag carried by the response |
| trap_evt | input | 1 | Translation fault on this turn |
| quiesce_evt | input | 1 | Quiesce instruction fetched on this turn |
| status | output | 4 | Current status code |
| redirect_vld | output | 1 | New PC is valid this cycle |
| redirect_pc | output | PC_W | New fetch PC |
| drop_rsp | output | 1 | Current response is discarded |
| stall_cycles | output | CNT_W | Saturating blocked-cycle count |
| squash_cycles | output | CNT_W | Saturating squashing-cycle count |

## Verification
Every state transition appears on `status` one cycle after its cause. A wrong next-state choice therefore shows up in the first sample after the stimulus, and the test table checks the code after every step. A stall flag that was lost or left set stays hidden until the thread tries to leave Blocked, so the multi-stage release order is tested on its own. A stale or mismatched tag shows on `drop_rsp` in the same cycle, and as a wrong status one cycle later if the response was taken by mistake. A redirect that used the wrong source or was wrongly suppressed is visible on the strobe and PC one cycle after the squash.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef enum logic [3:0] {
    FS_IDLE       = 4'd0,
    FS_RUN        = 4'd1,
    FS_SQUASH     = 4'd2,
    FS_BLOCK      = 4'd3,
    FS_WAIT_RSP   = 4'd4,
    FS_WAIT_RETRY = 4'd5,
    FS_FILL_DONE  = 4'd6,
    FS_TRAP       = 4'd7,
    FS_QUIESCE    = 4'd8
  } fstat_e;

  // sticky flag update: set dominates nothing, clear removes
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return (cur | set) & ~clr;
  endfunction

  // states that ignore a stall request
  function automatic logic stall_exempt(fstat_e s);
    return (s == FS_WAIT_RSP) || (s == FS_WAIT_RETRY) ||
           (s == FS_TRAP)     || (s == FS_QUIESCE);
  endfunction

endpackage

// File: rtl/ftc_stall_flags.sv
module ftc_stall_flags
  import ftc_pkg::*;
#(
  parameter int NSTG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTG-1:0] set,
  input  logic [NSTG-1:0] clr,
  output logic [NSTG-1:0] flags_nxt
);

  logic [NSTG-1:0] flags_q;

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    assign flags_nxt[i] = flag_next(flags_q[i], set[i], clr[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_nxt[i];
    end

    p_set_sticks_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags_q[i]);
    p_clr_drops_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !flags_q[i]);
    p_hold_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!set[i] && !clr[i]) |=> $stable(flags_q[i]));
  end

  p_set_clr_excl_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (set & clr) == '0);

endmodule

// File: rtl/ftc_sat_cnt.sv
module ftc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  function automatic logic [W-1:0] sat_inc(logic [W-1:0] v, logic en);
    return (en && v != CMAX) ? v + W'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= sat_inc(cnt, inc);
  end

  p_cnt_hold_max_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX) |=> (cnt == CMAX));
  p_cnt_idle_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
  p_cnt_step_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != CMAX) |=> (cnt == $past(cnt) + W'(1)));

endmodule

// File: rtl/ftc_status_fsm.sv
module ftc_status_fsm
  import ftc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_any,
  input  logic             late_sq,
  input  logic [PC_W-1:0]  late_pc,
  input  logic             late_busy,
  input  logic             early_sq,
  input  logic [PC_W-1:0]  early_pc,
  input  logic             fetch_turn,
  input  logic             miss_send,
  input  logic             miss_nack,
  input  logic             retry_ok,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic             trap_evt,
  input  logic             quiesce_evt,
  output fstat_e           st_q,
  output logic             redirect_vld,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             drop_rsp
);

  fstat_e           st_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             any_squash;
  logic             early_take;
  logic             redir_d;
  logic [PC_W-1:0]  redir_pc_d;
  logic             rsp_take;

  // named events used by the assertions below
  assign any_squash = late_sq | late_busy | early_sq;
  assign early_take = early_sq & ~late_sq & ~late_busy & (st_q != FS_SQUASH);
  assign redir_d    = late_sq | early_take;
  assign redir_pc_d = late_sq ? late_pc : early_pc;
  assign rsp_take   = rsp_valid && (st_q == FS_WAIT_RSP) &&
                      (rsp_tag == tag_q) && !any_squash;
  assign drop_rsp   = rsp_valid & ~rsp_take;

  always_comb begin
    st_d  = st_q;
    tag_d = tag_q;
    if (late_sq || late_busy || early_sq) begin
      st_d = FS_SQUASH;
    end else if (stall_any && !stall_exempt(st_q)) begin
      st_d = FS_BLOCK;
    end else begin
      unique case (st_q)
        FS_BLOCK, FS_SQUASH: st_d = FS_RUN;
        FS_IDLE, FS_FILL_DONE: begin
          if (fetch_turn) st_d = FS_RUN;
        end
        FS_RUN: begin
          if (fetch_turn) begin
            if (trap_evt) begin
              st_d = FS_TRAP;
            end else if (miss_send) begin
              if (miss_nack) begin
                st_d = FS_WAIT_RETRY;
              end else begin
                st_d  = FS_WAIT_RSP;
                tag_d = req_tag;
              end
            end else if (quiesce_evt) begin
              st_d = FS_QUIESCE;
            end
          end
        end
        FS_WAIT_RSP: begin
          if (rsp_take) st_d = stall_any ? FS_BLOCK : FS_FILL_DONE;
        end
        FS_WAIT_RETRY: begin
          if (retry_ok) begin
            st_d  = FS_WAIT_RSP;
            tag_d = req_tag;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= FS_IDLE;
      tag_q        <= '0;
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
    end else begin
      st_q         <= st_d;
      tag_q        <= tag_d;
      redirect_vld <= redir_d;
      if (redir_d) redirect_pc <= redir_pc_d;
    end
  end

  p_late_wins_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    late_sq |=> (st_q == FS_SQUASH) && redirect_vld &&
                (redirect_pc == $past(late_pc)));
  p_busy_holds_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (late_busy && !late_sq) |=> (st_q == FS_SQUASH) && !redirect_vld);
  p_early_ignored_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (early_sq && st_q == FS_SQUASH && !late_sq) |=> !redirect_vld);
  p_miss_kept_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_WAIT_RSP && !any_squash && !rsp_take) |=> (st_q == FS_WAIT_RSP));
  p_release_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == FS_BLOCK || st_q == FS_SQUASH) && !stall_any && !any_squash)
      |=> (st_q == FS_RUN));
  p_stale_drop_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && st_q != FS_WAIT_RSP) |-> drop_rsp);
  p_fill_leaves_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> (st_q == FS_BLOCK || st_q == FS_FILL_DONE));
  p_park_sticky_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == FS_TRAP || st_q == FS_QUIESCE) && !any_squash)
      |=> (st_q == $past(st_q)));
  p_legal_code_r13 : assert property (@(posedge clk) disable iff (!rst_n)
    st_q <= FS_QUIESCE);

endmodule

// File: rtl/fetch_thread_ctl.sv
module fetch_thread_ctl
  import ftc_pkg::*;
#(
  parameter int NSTG  = 4,
  parameter int PC_W  = 32,
  parameter int TAG_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTG-1:0]  blk_set,
  input  logic [NSTG-1:0]  blk_clr,
  input  logic             ctx_stall,
  input  logic             late_sq,
  input  logic [PC_W-1:0]  late_pc,
  input  logic             late_busy,
  input  logic             early_sq,
  input  logic [PC_W-1:0]  early_pc,
  input  logic             fetch_turn,
  input  logic             miss_send,
  input  logic             miss_nack,
  input  logic             retry_ok,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic             trap_evt,
  input  logic             quiesce_evt,
  output logic [3:0]       status,
  output logic             redirect_vld,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             drop_rsp,
  output logic [CNT_W-1:0] stall_cycles,
  output logic [CNT_W-1:0] squash_cycles
);

  logic [NSTG-1:0] flags_nxt;
  logic            stall_any;
  fstat_e          st;
  logic            in_block;
  logic            in_squash;

  ftc_stall_flags #(.NSTG(NSTG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (blk_set),
    .clr       (blk_clr),
    .flags_nxt (flags_nxt)
  );

  assign stall_any = (|flags_nxt) | ctx_stall;

  ftc_status_fsm #(.PC_W(PC_W), .TAG_W(TAG_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_any    (stall_any),
    .late_sq      (late_sq),
    .late_pc      (late_pc),
    .late_busy    (late_busy),
    .early_sq     (early_sq),
    .early_pc     (early_pc),
    .fetch_turn   (fetch_turn),
    .miss_send    (miss_send),
    .miss_nack    (miss_nack),
    .retry_ok     (retry_ok),
    .req_tag      (req_tag),
    .rsp_valid    (rsp_valid),
    .rsp_tag      (rsp_tag),
    .trap_evt     (trap_evt),
    .quiesce_evt  (quiesce_evt),
    .st_q         (st),
    .redirect_vld (redirect_vld),
    .redirect_pc  (redirect_pc),
    .drop_rsp     (drop_rsp)
  );

  assign status    = st;
  assign in_block  = (st == FS_BLOCK);
  assign in_squash = (st == FS_SQUASH);

  ftc_sat_cnt #(.W(CNT_W)) u_stall_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (in_block),
    .cnt   (stall_cycles)
  );

  ftc_sat_cnt #(.W(CNT_W)) u_squash_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (in_squash),
    .cnt   (squash_cycles)
  );

endmodule

// File: tb/test_fetch_thread_ctl.sv
module test_fetch_thread_ctl;

  localparam int NSTG = 4, PC_W = 32, TAG_W = 4, CNT_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [NSTG-1:0] blk_set, blk_clr;
  logic ctx_stall, late_sq, late_busy, early_sq, fetch_turn;
  logic miss_send, miss_nack, retry_ok, rsp_valid, trap_evt, quiesce_evt;
  logic [PC_W-1:0] late_pc, early_pc;
  logic [TAG_W-1:0] req_tag, rsp_tag;
  logic [3:0] status;
  logic redirect_vld, drop_rsp;
  logic [PC_W-1:0] redirect_pc;
  logic [CNT_W-1:0] stall_cycles, squash_cycles;

  fetch_thread_ctl #(.NSTG(NSTG), .PC_W(PC_W), .TAG_W(TAG_W), .CNT_W(CNT_W))
  i_fetch_thread_ctl (
    .clk(clk), .rst_n(rst_n), .blk_set(blk_set), .blk_clr(blk_clr),
    .ctx_stall(ctx_stall), .late_sq(late_sq), .late_pc(late_pc),
    .late_busy(late_busy), .early_sq(early_sq), .early_pc(early_pc),
    .fetch_turn(fetch_turn), .miss_send(miss_send), .miss_nack(miss_nack),
    .retry_ok(retry_ok), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .trap_evt(trap_evt), .quiesce_evt(quiesce_evt),
    .status(status), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
    .drop_rsp(drop_rsp), .stall_cycles(stall_cycles), .squash_cycles(squash_cycles)
  );

  // event bits of a table row
  localparam logic [11:0] E_CTX = 12'h800, E_LSQ = 12'h400, E_LBZ = 12'h200,
    E_ESQ = 12'h100, E_TURN = 12'h080, E_SEND = 12'h040, E_NACK = 12'h020,
    E_RTY = 12'h010, E_RSP = 12'h008, E_TOK = 12'h004, E_TRAP = 12'h002,
    E_QUI = 12'h001;

  typedef struct packed {
    logic [3:0]  set;
    logic [3:0]  clr;
    logic [11:0] ev;
    logic [3:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VTAB [NV] = '{
    '{4'h0, 4'h0, E_TURN,               4'd1, 4'd9},   // R9 idle -> run
    '{4'h0, 4'h0, E_TURN | E_SEND,      4'd4, 4'd10},  // R10 miss sent
    '{4'h1, 4'h0, 12'h000,              4'd4, 4'd5},   // R5 miss not stalled
    '{4'h0, 4'h0, E_RSP,                4'd4, 4'd8},   // R8 wrong tag
    '{4'h0, 4'h0, E_RSP | E_TOK,        4'd3, 4'd9},   // R9 fill under stall
    '{4'h0, 4'h1, 12'h000,              4'd1, 4'd6},   // R6 release
    '{4'h0, 4'h0, E_TURN|E_SEND|E_NACK, 4'd5, 4'd10},  // R10 refused
    '{4'h0, 4'h0, E_CTX,                4'd5, 4'd5},   // R5 retry not stalled
    '{4'h0, 4'h0, E_RTY,                4'd4, 4'd10},  // R10 resend
    '{4'h0, 4'h0, E_RSP | E_TOK,        4'd6, 4'd9},   // R9 fill done
    '{4'h0, 4'h0, E_TURN,               4'd1, 4'd9},   // R9 done -> run
    '{4'h4, 4'h0, 12'h000,              4'd3, 4'd5},   // R5 block
    '{4'h0, 4'h0, 12'h000,              4'd3, 4'd1},   // R1 sticky
    '{4'h0, 4'h4, 12'h000,              4'd1, 4'd6},   // R6 release
    '{4'h0, 4'h0, E_ESQ,                4'd2, 4'd4},   // R4 early squash
    '{4'h0, 4'h0, E_ESQ,                4'd2, 4'd4},   // R4 already squashing
    '{4'h0, 4'h0, 12'h000,              4'd1, 4'd6},   // R6
    '{4'h0, 4'h0, E_LSQ,                4'd2, 4'd2},   // R2
    '{4'h0, 4'h0, E_LBZ,                4'd2, 4'd3},   // R3
    '{4'h0, 4'h0, 12'h000,              4'd1, 4'd6},   // R6
    '{4'h0, 4'h0, E_TURN | E_TRAP,      4'd7, 4'd11},  // R11 trap
    '{4'h2, 4'h0, 12'h000,              4'd7, 4'd11},  // R11 stall ignored
    '{4'h0, 4'h0, E_TURN,               4'd7, 4'd11},  // R11 turn ignored
    '{4'h0, 4'h2, 12'h000,              4'd7, 4'd11},  // R11
    '{4'h0, 4'h0, E_LSQ,                4'd2, 4'd11},  // R11 squash leaves
    '{4'h0, 4'h0, 12'h000,              4'd1, 4'd6},   // R6
    '{4'h0, 4'h0, E_TURN | E_QUI,       4'd8, 4'd11},  // R11 quiesce
    '{4'h0, 4'h0, E_ESQ,                4'd2, 4'd11},  // R11 squash leaves
    '{4'h0, 4'h0, 12'h000,              4'd1, 4'd6},   // R6
    '{4'h0, 4'h0, E_TURN | E_SEND,      4'd4, 4'd10},  // R10
    '{4'h0, 4'h0, E_LSQ,                4'd2, 4'd7},   // R7 abandon miss
    '{4'h0, 4'h0, 12'h000,              4'd1, 4'd6},   // R6
    '{4'h0, 4'h0, E_RSP | E_TOK,        4'd1, 4'd7},   // R7 stale response
    '{4'h0, 4'h0, E_CTX,                4'd3, 4'd5},   // R5 context stall
    '{4'h0, 4'h0, 12'h000,              4'd1, 4'd6}    // R6
  };

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    blk_set = '0; blk_clr = '0; ctx_stall = 0; late_sq = 0; late_busy = 0;
    early_sq = 0; fetch_turn = 0; miss_send = 0; miss_nack = 0; retry_ok = 0;
    rsp_valid = 0; trap_evt = 0; quiesce_evt = 0;
    late_pc = 32'h40; early_pc = 32'h80; req_tag = 4'd5; rsp_tag = 4'd9;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    step(); step(); step();
    // R13 reset state
    check("R13 status", 32'(status), 32'd0);
    check("R13 redirect_vld", 32'(redirect_vld), 32'd0);
    check("R13 counters", 32'({stall_cycles, squash_cycles}), 32'd0);
    rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      idle_inputs();
      blk_set     = VTAB[k].set;
      blk_clr     = VTAB[k].clr;
      ctx_stall   = VTAB[k].ev[11];
      late_sq     = VTAB[k].ev[10];
      late_busy   = VTAB[k].ev[9];
      early_sq    = VTAB[k].ev[8];
      fetch_turn  = VTAB[k].ev[7];
      miss_send   = VTAB[k].ev[6];
      miss_nack   = VTAB[k].ev[5];
      retry_ok    = VTAB[k].ev[4];
      rsp_valid   = VTAB[k].ev[3];
      rsp_tag     = VTAB[k].ev[2] ? 4'd5 : 4'd9;
      trap_evt    = VTAB[k].ev[1];
      quiesce_evt = VTAB[k].ev[0];
      step();
      check($sformatf("R%0d row %0d status", VTAB[k].req, k), 32'(status), 32'(VTAB[k].exp));
    end

    // R2 late redirect carries the late PC for one cycle
    do_reset();
    fetch_turn = 1; step(); fetch_turn = 0;
    late_sq = 1; late_pc = 32'h1A4; early_sq = 1; early_pc = 32'h2B0; step();
    idle_inputs();
    check("R2 redirect_vld", 32'(redirect_vld), 32'd1);
    check("R2 redirect_pc", redirect_pc, 32'h1A4);
    check("R2 status", 32'(status), 32'd2);
    step();
    check("R2 strobe one cycle", 32'(redirect_vld), 32'd0);

    // R4 early redirect, then ignored while squashing
    early_sq = 1; early_pc = 32'h2B0; step();
    check("R4 redirect_vld", 32'(redirect_vld), 32'd1);
    check("R4 redirect_pc", redirect_pc, 32'h2B0);
    early_pc = 32'h3C0; step();
    check("R4 ignored no strobe", 32'(redirect_vld), 32'd0);
    check("R4 ignored status", 32'(status), 32'd2);
    idle_inputs(); step();
    check("R6 back to run", 32'(status), 32'd1);

    // R8 drop strobe on stale and accepted responses
    rsp_valid = 1; rsp_tag = 4'd5; #1;
    check("R8 stale drop", 32'(drop_rsp), 32'd1);
    rsp_valid = 0; step();
    fetch_turn = 1; miss_send = 1; req_tag = 4'd5; step();
    idle_inputs(); rsp_valid = 1; rsp_tag = 4'd5; #1;
    check("R8 accepted no drop", 32'(drop_rsp), 32'd0);
    step(); idle_inputs();
    check("R9 fill done", 32'(status), 32'd6);

    // R12 squash counter
    do_reset();
    late_sq = 1; step(); late_sq = 0;
    late_busy = 1; step(); step(); step(); late_busy = 0;
    step();
    check("R12 squash_cycles", 32'(squash_cycles), 32'd4);
    check("R12 status after squash", 32'(status), 32'd1);

    // R12 stall counter saturation
    do_reset();
    blk_set = 4'h8; step(); blk_set = '0;
    for (int i = 0; i < 5; i++) step();
    check("R12 stall_cycles mid", 32'(stall_cycles), 32'd5);
    for (int i = 0; i < 20; i++) step();
    check("R12 stall_cycles saturated", 32'(stall_cycles), 32'd15);
    check("R5 still blocked", 32'(status), 32'd3);

    // R1 several flags release one by one
    blk_clr = 4'h8; step(); blk_clr = '0;
    check("R6 released", 32'(status), 32'd1);
    blk_set = 4'h3; step(); blk_set = '0;
    check("R1 two flags", 32'(status), 32'd3);
    blk_clr = 4'h1; step(); blk_clr = '0;
    check("R1 one flag left", 32'(status), 32'd3);
    blk_clr = 4'h2; step(); blk_clr = '0;
    check("R1 all clear", 32'(status), 32'd1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule